// File: doc/BRIEF.md
# Selectable DS3 Line-Code Encoder

This block sits between a transmit framer and a line interface unit. It accepts the outbound serial DS3 stream one bit per clock and drives it onto two rails, one for positive pulses and one for negative pulses, together with a transmit line clock. A two-bit configuration input selects the line code at run time. The choices are single-rail unipolar, alternate mark inversion (AMI), and bipolar coding with three-zero substitution (B3ZS) built on top of AMI.

Every bit passes through a three-stage look-ahead pipeline. A run of three zeros is therefore seen complete before its first zero reaches the output. All codes use the same latency, so the timing of the rails does not change when the code is switched. A substitution state machine has three states. ST_PASS codes ordinary bits. ST_SUB_MID emits the middle zero of a substitution. ST_SUB_END emits the closing violation pulse.

The machine changes state as follows. ST_PASS goes to ST_SUB_MID when all three pipeline slots hold valid zeros and B3ZS is selected, and stays in ST_PASS otherwise. ST_SUB_MID goes to ST_SUB_END while B3ZS stays selected, and falls back to ST_PASS if the code is changed. ST_SUB_END always returns to ST_PASS. A rail stage tracks two things: the polarity of the last pulse sent, and whether the number of pulses sent since the last substitution is odd or even.

Top module: `lcode_tx`

## Requirements
- R1: A synchronous reset (rst high) clears both rails by the next clock edge and clears the pipeline, the polarity state and the pulse-parity state. The first bipolar pulse after reset goes on the positive rail.
- R2: A bit sampled on din at rising edge k appears on the rails after rising edge k+3, in every code. After reset, the first three rising edges produce no pulse.
- R3: With mode 2'b00 (unipolar), a 1 bit drives tx_pos high with tx_neg low, and a 0 bit leaves both rails low.
- R4: With mode 2'b01 (AMI), each 1 bit is a pulse of the opposite polarity to the previous pulse, and each 0 bit leaves both rails low. Runs of zeros of any length are sent as zeros.
- R5: With mode 2'b10 (B3ZS), three consecutive zeros are sent as 0,0,V when an odd number of pulses has been sent since the last substitution. V is a pulse of the same polarity as the pulse before it.
- R6: With mode 2'b10, three consecutive zeros are sent as B,0,V when that number is even, including zero pulses since reset. B is a normal alternating pulse, and V has the same polarity as B.
- R7: The pulse count used by R5 and R6 restarts at zero after each substitution. A longer zero run is replaced as back-to-back, non-overlapping groups of three, each group choosing its own pattern.
- R8: tx_pos and tx_neg are never high in the same bit period.
- R9: Mode 2'b11 codes exactly as AMI.
- R10: tx_lclk is a copy of clk. The rails change only on the rising edge, so they can be sampled on the falling edge.
- R11: In mode 2'b10, a run of one or two zeros that ends in a 1 bit is sent as plain zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one data bit per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Line code select: 00 unipolar, 01 AMI, 10 B3ZS, 11 AMI |
| din | input | 1 | Serial outbound data bit from the framer |
| tx_pos | output | 1 | Positive-pulse rail |
| tx_neg | output | 1 | Negative-pulse rail |
| tx_lclk | output | 1 | Transmit line clock toward the line interface unit |

## Verification
The bench builds the block with its default look-ahead depth of three. That depth equals the B3ZS run length, so a single 16-bit stream after reset can contain a zero run that starts at reset with even parity, a run after an odd pulse count, six or more zeros in a row, and a two-zero gap. Every rail value is compared at the exact bit position after the three-cycle delay, and the fill cycles after reset are compared too. This puts latency, polarity after reset and pattern choice within reach of each vector.

// File: rtl/lcode_pkg.sv
`timescale 1ns/1ps
package lcode_pkg;

    // Zero-run length replaced by the substitution code; also the look-ahead depth.
    localparam int RUN_LEN = 3;

    typedef enum logic [1:0] {
        MODE_UNI     = 2'b00,
        MODE_AMI     = 2'b01,
        MODE_B3ZS    = 2'b10,
        MODE_AMI_ALT = 2'b11
    } lc_mode_e;

    // Symbol handed from the substitution machine to the rail stage.
    typedef enum logic [1:0] {
        SYM_ZERO = 2'b00,
        SYM_MARK = 2'b01,
        SYM_VIOL = 2'b10
    } lc_sym_e;

    typedef enum logic [1:0] {
        ST_PASS    = 2'b00,
        ST_SUB_MID = 2'b01,
        ST_SUB_END = 2'b10
    } lc_state_e;

endpackage

// File: rtl/lcode_delay.sv
`timescale 1ns/1ps
module lcode_delay #(
    parameter int DEPTH = lcode_pkg::RUN_LEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    output logic [DEPTH-1:0] bits_o,
    output logic [DEPTH-1:0] vld_o
);
    // Slot 0 holds the newest bit, slot DEPTH-1 the oldest.
    logic [DEPTH-1:0] bit_q;
    logic [DEPTH-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q[0] <= 1'b0;
            vld_q[0] <= 1'b0;
        end else begin
            bit_q[0] <= din;
            vld_q[0] <= 1'b1;
        end
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q[g] <= 1'b0;
                vld_q[g] <= 1'b0;
            end else begin
                bit_q[g] <= bit_q[g-1];
                vld_q[g] <= vld_q[g-1];
            end
        end
    end

    assign bits_o = bit_q;
    assign vld_o  = vld_q;

    // R2
    valid_fill_chk: assert property (@(posedge clk) disable iff (rst)
        vld_q[DEPTH-1] |=> vld_q[DEPTH-1]);

endmodule

// File: rtl/lcode_subst_fsm.sv
`timescale 1ns/1ps
module lcode_subst_fsm
    import lcode_pkg::*;
#(
    parameter int DEPTH = RUN_LEN
) (
    input  logic             clk,
    input  logic             rst,
    input  lc_mode_e         mode_i,
    input  logic [DEPTH-1:0] bits_i,
    input  logic [DEPTH-1:0] vld_i,
    input  logic             parity_odd_i,
    output lc_sym_e          sym_o
);
    lc_state_e state_q, state_d;
    logic      is_b3;
    logic      run_zero;
    logic      head_one;

    assign is_b3    = (mode_i == MODE_B3ZS);
    assign run_zero = is_b3 && (vld_i == '1) && (bits_i == '0);
    assign head_one = vld_i[DEPTH-1] && bits_i[DEPTH-1];

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_PASS;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        sym_o   = SYM_ZERO;
        unique case (state_q)
            ST_PASS: begin
                if (run_zero) begin
                    sym_o   = parity_odd_i ? SYM_ZERO : SYM_MARK;
                    state_d = ST_SUB_MID;
                end else if (head_one) begin
                    sym_o = SYM_MARK;
                end
            end
            ST_SUB_MID: begin
                sym_o   = SYM_ZERO;
                state_d = is_b3 ? ST_SUB_END : ST_PASS;
            end
            ST_SUB_END: begin
                sym_o   = is_b3 ? SYM_VIOL : SYM_ZERO;
                state_d = ST_PASS;
            end
            default: begin
                sym_o   = SYM_ZERO;
                state_d = ST_PASS;
            end
        endcase
    end

    // R5
    sub_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SUB_MID && is_b3) |=> (state_q == ST_SUB_END));

    // R7
    sub_return_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SUB_END) |=> (state_q == ST_PASS));

endmodule

// File: rtl/lcode_rails.sv
`timescale 1ns/1ps
module lcode_rails
    import lcode_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lc_mode_e mode_i,
    input  lc_sym_e  sym_i,
    output logic     pos_o,
    output logic     neg_o,
    output logic     parity_odd_o
);
    logic pos_q, neg_q;
    logic last_pos_q, par_q;
    logic pos_d, neg_d, last_pos_d, par_d;
    logic is_uni;

    assign is_uni = (mode_i == MODE_UNI);

    always_comb begin
        pos_d      = 1'b0;
        neg_d      = 1'b0;
        last_pos_d = last_pos_q;
        par_d      = par_q;
        unique case (sym_i)
            SYM_ZERO: begin
                pos_d = 1'b0;
            end
            SYM_MARK: begin
                if (is_uni) begin
                    pos_d = 1'b1;
                end else begin
                    pos_d      = ~last_pos_q;
                    neg_d      = last_pos_q;
                    last_pos_d = ~last_pos_q;
                    par_d      = ~par_q;
                end
            end
            SYM_VIOL: begin
                pos_d = last_pos_q;
                neg_d = ~last_pos_q;
                par_d = 1'b0;
            end
            default: begin
                pos_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q      <= 1'b0;
            neg_q      <= 1'b0;
            last_pos_q <= 1'b0;
            par_q      <= 1'b0;
        end else begin
            pos_q      <= pos_d;
            neg_q      <= neg_d;
            last_pos_q <= last_pos_d;
            par_q      <= par_d;
        end
    end

    assign pos_o        = pos_q;
    assign neg_o        = neg_q;
    assign parity_odd_o = par_q;

    // R8
    rails_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pos_q && neg_q));

    // R3
    uni_neg_low_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_i) == MODE_UNI) |-> !neg_q);

    // R4
    ami_alt_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_i == SYM_MARK && !is_uni) |=> ((pos_q != neg_q) && (last_pos_q != $past(last_pos_q))));

    // R6
    viol_pol_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_i == SYM_VIOL) |=> (pos_q == $past(last_pos_q)) && (par_q == 1'b0));

endmodule

// File: rtl/lcode_tx.sv
`timescale 1ns/1ps
module lcode_tx
    import lcode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       din,
    output logic       tx_pos,
    output logic       tx_neg,
    output logic       tx_lclk
);
    localparam int DEPTH = RUN_LEN;

    lc_mode_e         mode_e;
    logic [DEPTH-1:0] pipe_bits;
    logic [DEPTH-1:0] pipe_vld;
    logic             parity_odd;
    lc_sym_e          sym;

    assign mode_e = lc_mode_e'(mode);

    lcode_delay #(.DEPTH(DEPTH)) u_delay (
        .clk    (clk),
        .rst    (rst),
        .din    (din),
        .bits_o (pipe_bits),
        .vld_o  (pipe_vld)
    );

    lcode_subst_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .mode_i       (mode_e),
        .bits_i       (pipe_bits),
        .vld_i        (pipe_vld),
        .parity_odd_i (parity_odd),
        .sym_o        (sym)
    );

    lcode_rails u_rails (
        .clk          (clk),
        .rst          (rst),
        .mode_i       (mode_e),
        .sym_i        (sym),
        .pos_o        (tx_pos),
        .neg_o        (tx_neg),
        .parity_odd_o (parity_odd)
    );

    // R10: line clock forwarded from the bit clock
    assign tx_lclk = clk;

endmodule

// File: tb/lcode_tx_test.sv
`timescale 1ns/1ps
module lcode_tx_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       din = 1'b0;
    logic       tx_pos, tx_neg, tx_lclk;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #2.5 clk = ~clk;

    lcode_tx uut (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .din     (din),
        .tx_pos  (tx_pos),
        .tx_neg  (tx_neg),
        .tx_lclk (tx_lclk)
    );

    // Bits are listed in send order, leftmost first.
    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] data;
        logic [15:0] pos;
        logic [15:0] neg;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        // R3: unipolar mixed pattern
        '{2'b00, 16'b1011001000001101, 16'b1011001000001101, 16'b0000000000000000, 4'd3},
        // R4: AMI alternation, zero runs kept
        '{2'b01, 16'b1101000000111000, 16'b1001000000010000, 16'b0100000000101000, 4'd4},
        // R9: mode 11 equals AMI
        '{2'b11, 16'b1101000000111000, 16'b1001000000010000, 16'b0100000000101000, 4'd9},
        // R5, R6, R11: 00V after odd count, B0V after even, two-zero gap kept
        '{2'b10, 16'b1000110001001000, 16'b1001010001000101, 16'b0000101010001000, 4'd5},
        // R6, R7: runs from reset, back-to-back groups
        '{2'b10, 16'b0000001000000000, 16'b1010001001000101, 16'b0001010000101000, 4'd7},
        // R1, R4: first pulse positive after reset, long zero run in AMI
        '{2'b01, 16'b0000000010000001, 16'b0000000010000000, 16'b0000000000000001, 4'd1},
        // R3: unipolar all ones
        '{2'b00, 16'b1111111111111111, 16'b1111111111111111, 16'b0000000000000000, 4'd3}
    };

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        rst  = 1'b1;
        din  = 1'b0;
        mode = v.mode;
        @(negedge clk);
        chk("R1 rails cleared by reset", {tx_pos, tx_neg}, 2'b00);
        rst = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (i >= 1 && i <= 3) begin
                chk($sformatf("R2 fill cycle %0d (vector R%0d)", i, v.req), {tx_pos, tx_neg}, 2'b00);
            end else if (i >= 4) begin
                chk($sformatf("R%0d bit %0d", v.req, i - 4), {tx_pos, tx_neg},
                    {v.pos[15 - (i - 4)], v.neg[15 - (i - 4)]});
            end
            din = (i < 16) ? v.data[15 - i] : 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        #50000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);

        for (int k = 0; k < NVEC; k++) begin
            run_vec(VECS[k]);
        end

        // R1: reset in the middle of an AMI stream of ones
        @(negedge clk);
        rst  = 1'b0;
        mode = 2'b01;
        din  = 1'b1;
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-stream reset clears rails", {tx_pos, tx_neg}, 2'b00);
        rst = 1'b0;
        din = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 first pulse after reset positive", {tx_pos, tx_neg}, 2'b10);
        @(negedge clk);
        chk("R4 second pulse negative", {tx_pos, tx_neg}, 2'b01);

        // R10: line clock follows the bit clock
        @(posedge clk);
        #1;
        chk("R10 line clock high", {1'b0, tx_lclk}, 2'b01);
        @(negedge clk);
        #1;
        chk("R10 line clock low", {1'b0, tx_lclk}, 2'b00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule